// File: doc/BRIEF.md
# Clock Output Stop and Frequency-Select Controller

This block controls the output side of a multi-output clock synthesizer. For each output clock it decides whether the clock runs, is held stopped, or is released to high impedance. It also picks the 6-bit frequency code that steers the synthesizer core. Inputs are per-output enable bits from the register file, the hardware straps, four active-low stop inputs and the software frequency field. Outputs are one gate enable per clock, a global tristate and the frequency code. Clock generation, dividers and the PLL are outside the block. The source clocks arrive as free-running levels, oversampled by the block clock.

The straps are the frequency select, the pin-mode strap and the AGP-rate select. They are captured once, in the first cycle after reset, and then held. When the pin-mode strap is 1, four SDRAM outputs are given up to serve as stop inputs: CPU stop, SDRAM stop, PCI stop and power-down. When the strap is 0, those stop inputs are treated as inactive. Every gate enable is reloaded only in a cycle where its source clock is sampled low. This means an output pulse is never cut short and never starts as a fragment.

Top module: `clk_stop_select`

## Requirements
- R1: While reset is asserted, every gate output (`cpu_gate`, `sdr_gate`, `pci_gate`, `agp_gate`, `fix_gate`) is 0.
- R2: `strap_fs`, `strap_mode` and `strap_agpsel` are captured in the first clock after reset is released. Later changes on those inputs have no effect on `freq_code` or `agp_sel` until the next reset.
- R3: When `freq_cfg[1]` is 0, `freq_code` is `{2'b00, captured strap_fs}`. When `freq_cfg[1]` is 1, `freq_code` equals `freq_cfg[7:2]`.
- R4: `out_tristate` is 1 exactly when `freq_cfg[0]` is 1.
- R5: With no stop or power-down active, each gate follows its enable bit: 1 runs the clock, 0 stops it.
- R6: A gate output changes only at a clock edge where its group's source clock input was sampled low.
- R7: A low `cpu_stop_n` (pin mode 1) stops all CPU gates except the highest-index one. That one is stopped only when `cpu_last_stoppable` is 1 and otherwise keeps running.
- R8: With the captured pin mode 0, all four stop inputs are ignored. With pin mode 1, SDRAM gates at indices SHR_LO to SHR_LO+3 (8 to 11 by default) are always 0.
- R9: A low `sdr_stop_n` stops all SDRAM gates and a low `pci_stop_n` stops all PCI gates (pin mode 1). Neither affects the CPU, AGP or fixed-rate gates.
- R10: A low `pd_n` (pin mode 1) stops every gate, including the free-running CPU clock, whatever the other stop inputs and the stoppable bit are. Releasing it restores the gates their enables call for.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, oversamples the source clocks |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_fs | input | 4 | Hardware frequency-select strap |
| strap_mode | input | 1 | Pin-mode strap (1 = four SDRAM pins become stop inputs) |
| strap_agpsel | input | 1 | AGP rate-select strap |
| freq_cfg | input | 8 | [7:2] software code, [1] source select, [0] tristate |
| cpu_en | input | N_CPU | CPU clock enables |
| cpu_last_stoppable | input | 1 | 1 = highest CPU clock obeys CPU stop |
| sdr_en | input | N_SDR | SDRAM clock enables |
| pci_en | input | N_PCI | PCI clock enables |
| agp_en | input | N_AGP | AGP clock enables |
| fix_en | input | N_FIX | Fixed-rate (48 / 24-48 MHz) clock enables |
| cpu_stop_n | input | 1 | CPU stop, active low |
| sdr_stop_n | input | 1 | SDRAM stop, active low |
| pci_stop_n | input | 1 | PCI stop, active low |
| pd_n | input | 1 | Power-down, active low |
| src_cpu | input | 1 | CPU source clock level |
| src_sdr | input | 1 | SDRAM source clock level |
| src_pci | input | 1 | PCI source clock level |
| src_agp | input | 1 | AGP source clock level |
| src_fix | input | 1 | Fixed-rate source clock level |
| cpu_gate | output | N_CPU | CPU gate enables |
| sdr_gate | output | N_SDR | SDRAM gate enables |
| pci_gate | output | N_PCI | PCI gate enables |
| agp_gate | output | N_AGP | AGP gate enables |
| fix_gate | output | N_FIX | Fixed-rate gate enables |
| out_tristate | output | 1 | Tristate all outputs |
| freq_code | output | 6 | Frequency code to the synthesizer |
| agp_sel | output | 1 | Captured AGP rate select |

## Verification
The assertions assume that each source clock level and each control input is steady around the rising edge of `clk`. The bench meets this by changing source levels, enables, stop inputs and straps only on the falling edge. The source clocks are slower than `clk` and hold each level for at least two samples, so every group sees low samples within a short window after a control change. The pin-mode strap can only change across a reset, so the bench runs the pin-mode-0 and pin-mode-1 cases in two separate reset phases.

// File: rtl/clk_stop_select.sv
module clk_stop_select #(
  parameter int N_CPU  = 3,
  parameter int N_SDR  = 13,
  parameter int N_PCI  = 6,
  parameter int N_AGP  = 2,
  parameter int N_FIX  = 2,
  parameter int SHR_LO = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       strap_fs,
  input  logic             strap_mode,
  input  logic             strap_agpsel,
  input  logic [7:0]       freq_cfg,
  input  logic [N_CPU-1:0] cpu_en,
  input  logic             cpu_last_stoppable,
  input  logic [N_SDR-1:0] sdr_en,
  input  logic [N_PCI-1:0] pci_en,
  input  logic [N_AGP-1:0] agp_en,
  input  logic [N_FIX-1:0] fix_en,
  input  logic             cpu_stop_n,
  input  logic             sdr_stop_n,
  input  logic             pci_stop_n,
  input  logic             pd_n,
  input  logic             src_cpu,
  input  logic             src_sdr,
  input  logic             src_pci,
  input  logic             src_agp,
  input  logic             src_fix,
  output logic [N_CPU-1:0] cpu_gate,
  output logic [N_SDR-1:0] sdr_gate,
  output logic [N_PCI-1:0] pci_gate,
  output logic [N_AGP-1:0] agp_gate,
  output logic [N_FIX-1:0] fix_gate,
  output logic             out_tristate,
  output logic [5:0]       freq_code,
  output logic             agp_sel
);

  localparam logic [N_SDR-1:0] SHR_MASK = {{(N_SDR-4){1'b0}}, 4'hF} << SHR_LO;

  logic       done_q, mode_q, agpsel_q;
  logic [3:0] fs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q   <= 1'b0;
      mode_q   <= 1'b0;
      agpsel_q <= 1'b0;
      fs_q     <= '0;
    end else if (!done_q) begin
      done_q   <= 1'b1;
      mode_q   <= strap_mode;
      agpsel_q <= strap_agpsel;
      fs_q     <= strap_fs;
    end
  end

  wire pd_act  = mode_q & ~pd_n;
  wire cpu_go  = ~mode_q | cpu_stop_n;
  wire sdr_go  = ~mode_q | sdr_stop_n;
  wire pci_go  = ~mode_q | pci_stop_n;

  logic [N_CPU-1:0] cpu_want;
  always_comb begin
    for (int i = 0; i < N_CPU; i++)
      cpu_want[i] = cpu_en[i] & ~pd_act &
                    ((i == N_CPU-1) ? (cpu_go | ~cpu_last_stoppable) : cpu_go);
  end

  wire [N_SDR-1:0] sdr_want = sdr_en & ~(mode_q ? SHR_MASK : '0) & {N_SDR{sdr_go & ~pd_act}};
  wire [N_PCI-1:0] pci_want = pci_en & {N_PCI{pci_go & ~pd_act}};
  wire [N_AGP-1:0] agp_want = agp_en & {N_AGP{~pd_act}};
  wire [N_FIX-1:0] fix_want = fix_en & {N_FIX{~pd_act}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_gate <= '0;
      sdr_gate <= '0;
      pci_gate <= '0;
      agp_gate <= '0;
      fix_gate <= '0;
    end else if (done_q) begin
      if (!src_cpu) cpu_gate <= cpu_want;
      if (!src_sdr) sdr_gate <= sdr_want;
      if (!src_pci) pci_gate <= pci_want;
      if (!src_agp) agp_gate <= agp_want;
      if (!src_fix) fix_gate <= fix_want;
    end
  end

  assign out_tristate = freq_cfg[0];
  assign freq_code    = freq_cfg[1] ? freq_cfg[7:2] : {2'b00, fs_q};
  assign agp_sel      = agpsel_q;

  p_cpu_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_gate != $past(cpu_gate)) |-> !$past(src_cpu));
  p_sdr_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sdr_gate != $past(sdr_gate)) |-> !$past(src_sdr));
  p_pci_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pci_gate != $past(pci_gate)) |-> !$past(src_pci));
  p_straps_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(done_q) && done_q) |-> ($stable(fs_q) && $stable(mode_q) && $stable(agpsel_q)));
  p_shared_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q |-> ((sdr_gate & SHR_MASK) == '0));
  p_pd_stops_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(done_q && mode_q && !pd_n && !src_cpu) |-> (cpu_gate == '0));
  p_freerun_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(done_q && pd_n && cpu_en[N_CPU-1] && !cpu_last_stoppable && !src_cpu)
      |-> cpu_gate[N_CPU-1]);

endmodule

// File: tb/test_clk_stop_select.sv
module test_clk_stop_select;
  localparam int NC = 3, NS = 13, NP = 6, NA = 2, NF = 2, SL = 8;

  logic clk = 0, rst_n = 0;
  logic [3:0] strap_fs = 4'b1010;
  logic strap_mode = 0, strap_agpsel = 1;
  logic [7:0] freq_cfg = 0;
  logic [NC-1:0] cpu_en = '1;
  logic cpu_last_stoppable = 0;
  logic [NS-1:0] sdr_en = '1;
  logic [NP-1:0] pci_en = '1;
  logic [NA-1:0] agp_en = '1;
  logic [NF-1:0] fix_en = '1;
  logic cpu_stop_n = 1, sdr_stop_n = 1, pci_stop_n = 1, pd_n = 1;
  logic src_cpu = 0, src_sdr = 0, src_pci = 0, src_agp = 0, src_fix = 0;
  logic [NC-1:0] cpu_gate;
  logic [NS-1:0] sdr_gate;
  logic [NP-1:0] pci_gate;
  logic [NA-1:0] agp_gate;
  logic [NF-1:0] fix_gate;
  logic out_tristate, agp_sel;
  logic [5:0] freq_code;

  int checks = 0, errors = 0, tick = 0;

  clk_stop_select i_clk_stop_select (.*);

  always #4 clk = ~clk;

  always @(negedge clk) begin
    tick++;
    src_cpu <= (tick % 4) < 2;
    src_sdr <= (tick % 6) < 3;
    src_pci <= (tick % 8) < 4;
    src_agp <= ((tick + 2) % 6) < 3;
    src_fix <= (tick % 10) < 5;
  end

  // behavioural reference model
  bit m_done, m_mode;
  bit [NC-1:0] m_cpu; bit [NS-1:0] m_sdr; bit [NP-1:0] m_pci;
  bit [NA-1:0] m_agp; bit [NF-1:0] m_fix;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_done = 0; m_mode = 0;
      m_cpu = 0; m_sdr = 0; m_pci = 0; m_agp = 0; m_fix = 0;
    end else if (!m_done) begin
      m_done = 1; m_mode = strap_mode;
    end else begin
      bit pd, cs, ss, ps;
      pd = m_mode && !pd_n;
      cs = m_mode && !cpu_stop_n;
      ss = m_mode && !sdr_stop_n;
      ps = m_mode && !pci_stop_n;
      if (!src_cpu)
        for (int i = 0; i < NC; i++) begin
          bit stopped;
          stopped = pd || (cs && (i != NC-1 || cpu_last_stoppable));
          m_cpu[i] = cpu_en[i] && !stopped;
        end
      if (!src_sdr)
        for (int i = 0; i < NS; i++)
          m_sdr[i] = sdr_en[i] && !pd && !ss && !(m_mode && i >= SL && i < SL + 4);
      if (!src_pci)
        for (int i = 0; i < NP; i++) m_pci[i] = pci_en[i] && !pd && !ps;
      if (!src_agp)
        for (int i = 0; i < NA; i++) m_agp[i] = agp_en[i] && !pd;
      if (!src_fix)
        for (int i = 0; i < NF; i++) m_fix[i] = fix_en[i] && !pd;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // continuous comparison against the model: R5 R6 R7 R8 R9 R10
  always @(negedge clk) if (rst_n && m_done) begin
    chk("R6 cpu gate vs model", 32'(cpu_gate), 32'(m_cpu));
    chk("R6 sdr gate vs model", 32'(sdr_gate), 32'(m_sdr));
    chk("R6 pci gate vs model", 32'(pci_gate), 32'(m_pci));
    chk("R6 agp gate vs model", 32'(agp_gate), 32'(m_agp));
    chk("R6 fix gate vs model", 32'(fix_gate), 32'(m_fix));
  end

  task automatic settle();
    repeat (16) @(negedge clk);
  endtask

  localparam logic [NS-1:0] SHARED = {{(NS-4){1'b0}}, 4'hF} << SL;

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset cpu", 32'(cpu_gate), 0);
    chk("R1 reset sdr", 32'(sdr_gate), 0);
    chk("R1 reset pci/agp/fix", 32'({pci_gate, agp_gate, fix_gate}), 0);
    rst_n = 1;
    settle();
    chk("R2 hw code", 32'(freq_code), 32'h0A);
    chk("R2 agp select", 32'(agp_sel), 1);
    chk("R5 cpu running", 32'(cpu_gate), 32'h7);
    chk("R5 sdr running", 32'(sdr_gate), 32'h1FFF);
    strap_fs = 4'b0101; strap_agpsel = 0;
    settle();
    chk("R2 straps held", 32'(freq_code), 32'h0A);
    chk("R2 agp held", 32'(agp_sel), 1);
    freq_cfg = {6'b110101, 2'b10};
    settle();
    chk("R3 sw code", 32'(freq_code), 32'h35);
    chk("R4 tristate off", 32'(out_tristate), 0);
    freq_cfg = {6'b110101, 2'b01};
    settle();
    chk("R3 hw code back", 32'(freq_code), 32'h0A);
    chk("R4 tristate on", 32'(out_tristate), 1);
    freq_cfg = 0; cpu_en = 3'b101; pci_en = 6'b000011;
    settle();
    chk("R5 cpu enables", 32'(cpu_gate), 32'h5);
    chk("R5 pci enables", 32'(pci_gate), 32'h03);
    cpu_en = '1; pci_en = '1;
    cpu_stop_n = 0; sdr_stop_n = 0; pci_stop_n = 0; pd_n = 0; cpu_last_stoppable = 1;
    settle();
    chk("R8 mode0 cpu ignores stops", 32'(cpu_gate), 32'h7);
    chk("R8 mode0 sdr ignores stops", 32'(sdr_gate), 32'h1FFF);
    chk("R8 mode0 pci ignores stops", 32'(pci_gate), 32'h3F);

    // phase B: pin mode 1
    @(negedge clk);
    rst_n = 0; strap_mode = 1;
    cpu_stop_n = 1; sdr_stop_n = 1; pci_stop_n = 1; pd_n = 1; cpu_last_stoppable = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    settle();
    chk("R8 mode1 shared pins off", 32'(sdr_gate), 32'(~SHARED & 13'h1FFF));
    cpu_stop_n = 0;
    settle();
    chk("R7 free-running last cpu", 32'(cpu_gate), 32'h4);
    cpu_last_stoppable = 1;
    settle();
    chk("R7 all cpu stopped", 32'(cpu_gate), 0);
    cpu_stop_n = 1; cpu_last_stoppable = 0; sdr_stop_n = 0;
    settle();
    chk("R9 sdr stopped", 32'(sdr_gate), 0);
    chk("R9 agp/fix unaffected", 32'({agp_gate, fix_gate}), 32'hF);
    chk("R9 cpu unaffected", 32'(cpu_gate), 32'h7);
    sdr_stop_n = 1; pci_stop_n = 0;
    settle();
    chk("R9 pci stopped", 32'(pci_gate), 0);
    chk("R9 sdr restored", 32'(sdr_gate), 32'(~SHARED & 13'h1FFF));
    pci_stop_n = 1; pd_n = 0;
    settle();
    chk("R10 pd cpu incl free-run", 32'(cpu_gate), 0);
    chk("R10 pd other gates", 32'({sdr_gate, pci_gate, agp_gate, fix_gate}), 0);
    pd_n = 1;
    settle();
    chk("R10 released cpu", 32'(cpu_gate), 32'h7);
    chk("R10 released fix", 32'(fix_gate), 32'h3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule